// File: doc/BRIEF.md
# Keyed Peripheral Reset-Line Controller

This block drives a vector of peripheral reset lines from a software-visible register. Each line has one bit in a line-reset register. A write to that register takes effect only when the top byte of the write data carries a fixed unlock key. The key guards against stray stores that would otherwise reset a peripheral.

An optional ownership register can be selected by parameter. It holds one bit per line and hands control of that line to software. When ownership is present, a line drives its reset only while both its line bit and its ownership bit are set. Software sets the ownership bit before it asserts a line, and clears it after it deasserts the line. To set or clear one line, software reads the register, changes one bit, and writes the value back with the key. A pulse is an assert followed by a deassert. The block does no sequencing of its own: it applies each accepted value as written.

The register port is a simple single-cycle write strobe with a combinational read. It has no handshake.

Top module: `keyed_reset_ctrl`

## Requirements
- R1: After the block's reset (rst_n low), every reset output is 0, and both the line register and the ownership register read back as 0.
- R2: A write to offset 0x18 whose data bits 31:24 equal 0x88 loads data bits NUM_LINES-1:0 into the line register. The new value is visible at the read port and the outputs right after that clock edge.
- R3: A write to offset 0x18 whose bits 31:24 differ from 0x88 is ignored. The line register and the outputs keep their values.
- R4: A read of offset 0x18 returns the line bits in bits NUM_LINES-1:0, and zeros in every bit above them, including the key byte 31:24.
- R5: With HAS_OWNER=1, a write to offset 0xFC stores data bits NUM_LINES-1:0 in the ownership register without any key. Reading offset 0xFC returns those bits, with zeros above them.
- R6: With HAS_OWNER=1, reset output i is 1 exactly when line bit i and ownership bit i are both 1. With HAS_OWNER=0, the output equals the line register and offset 0xFC reads 0.
- R7: Writes to any other offset change neither register nor any output, and reads of other offsets return 0.
- R8: The software sequence works line by line: set ownership, keyed assert, keyed deassert, clear ownership. It raises and then drops only the addressed line, and leaves the other lines as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data, bits 31:24 carry the key for the line register |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rst_lines | output | NUM_LINES | Active-high reset to each peripheral |

## Verification
Random writes mix correct and wrong keys at the line-register offset. This separates a design that checks the key byte from one that checks only part of it, or ignores it. Random ownership values interleaved with line writes show whether outputs are gated per bit or per vector. Stray writes to unrelated offsets, some of which carry the key, expose a decode that is too loose. Directed cases cover reset, key-byte readback, and the set-owner/assert/deassert/clear-owner sequence on a single line, with bystander lines held active. Together they check that a read-modify-write touches only its own bit.

// File: rtl/keyed_reset_ctrl.sv
module keyed_reset_ctrl #(
  parameter int          NUM_LINES = 24,
  parameter bit          HAS_OWNER = 1'b1,
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  UNLOCK    = 8'h88,
  parameter int          LINE_OFS  = 'h18,
  parameter int          OWN_OFS   = 'hFC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_LINES-1:0] rst_lines
);
  localparam int PADW = 32 - NUM_LINES;
  localparam logic [ADDR_W-1:0] A_LINE = ADDR_W'(LINE_OFS);
  localparam logic [ADDR_W-1:0] A_OWN  = ADDR_W'(OWN_OFS);

  logic [NUM_LINES-1:0] line_q;
  logic [NUM_LINES-1:0] own_q;
  logic                 hit_line, hit_own, key_ok;

  assign hit_line = bus_addr == A_LINE;
  assign hit_own  = bus_addr == A_OWN;
  assign key_ok   = bus_wdata[31:24] == UNLOCK;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          line_q <= '0;
    else if (bus_wr && hit_line && key_ok) line_q <= bus_wdata[NUM_LINES-1:0];

  generate
    if (HAS_OWNER) begin : g_own
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                 own_q <= '0;
        else if (bus_wr && hit_own) own_q <= bus_wdata[NUM_LINES-1:0];
      assign rst_lines = line_q & own_q;
    end else begin : g_noown
      assign own_q     = '0;
      assign rst_lines = line_q;
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (hit_line)     bus_rdata = {{PADW{1'b0}}, line_q};
    else if (hit_own) bus_rdata = {{PADW{1'b0}}, own_q};
  end

  AST_KEYED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && hit_line && key_ok |=> line_q == $past(bus_wdata[NUM_LINES-1:0])); // R2
  AST_BAD_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && hit_line && !key_ok |=> $stable(line_q) && $stable(rst_lines)); // R3
  AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !hit_line && !hit_own |=> $stable(line_q) && $stable(own_q) && $stable(rst_lines)); // R7
  AST_OUT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_lines & ~line_q) == '0); // R6
  AST_OWNER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    HAS_OWNER |-> (rst_lines & ~own_q) == '0); // R6
endmodule

// File: tb/keyed_reset_ctrl_bench.sv
module keyed_reset_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 24;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [N-1:0] rst_lines;
  logic [N-1:0] m_line = 0, m_own = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  keyed_reset_ctrl u_keyed_reset_ctrl (.clk, .rst_n, .bus_wr, .bus_addr,
    .bus_wdata, .bus_rdata, .rst_lines);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [N-1:0] exp_out(logic [N-1:0] l, logic [N-1:0] o);
    return l & o;
  endfunction
  function automatic logic [31:0] exp_read(logic [7:0] a, logic [N-1:0] l, logic [N-1:0] o);
    if (a == 8'h18) return {8'h00, l};
    if (a == 8'hFC) return {8'h00, o};
    return 32'h0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
    if (a == 8'h18 && d[31:24] == 8'h88) m_line = d[N-1:0];
    if (a == 8'hFC) m_own = d[N-1:0];
  endtask

  task automatic rd(logic [7:0] a, string req);
    bus_addr = a; #1;
    check(req, bus_rdata, exp_read(a, m_line, m_own));
  endtask

  task automatic chk_out(string req);
    check(req, {8'h0, rst_lines}, {8'h0, exp_out(m_line, m_own)});
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #(CLK_PERIOD*3);
    chk_out("R1 outputs after reset");
    rd(8'h18, "R1 line reg after reset");
    rd(8'hFC, "R1 owner reg after reset");
    @(negedge clk); rst_n = 1;

    wr(8'hFC, 32'hFFFF_FFFF);
    wr(8'h18, 32'h88A5_5A5A);
    rd(8'h18, "R2 keyed load / R4 key byte reads zero");
    chk_out("R2 outputs follow keyed load");
    wr(8'h18, 32'h8900_0000);
    rd(8'h18, "R3 near-miss key ignored");
    chk_out("R3 outputs hold");
    wr(8'h18, 32'h0800_0000);
    rd(8'h18, "R3 low-nibble key ignored");
    wr(8'hFC, 32'h1200_00F0);
    rd(8'hFC, "R5 owner write without key");
    chk_out("R6 owner gating");
    wr(8'h1C, 32'h88FF_FFFF);
    rd(8'h18, "R7 stray keyed write");
    rd(8'h1C, "R7 other offset reads zero");
    chk_out("R7 outputs unchanged");

    wr(8'hFC, 32'h0000_0003);
    wr(8'h18, 32'h8800_0001);
    chk_out("R8 bystander line 0 active");
    wr(8'hFC, 32'h0000_0083);
    chk_out("R8 owner set, line 7 still low");
    wr(8'h18, 32'h8800_0081);
    chk_out("R8 line 7 asserted");
    wr(8'h18, 32'h8800_0001);
    chk_out("R8 line 7 deasserted, line 0 kept");
    wr(8'hFC, 32'h0000_0003);
    chk_out("R8 owner cleared");
    rd(8'hFC, "R8 owner readback");

    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      int sel;
      sel = $urandom_range(0, 9);
      a = (sel < 5) ? 8'h18 : (sel < 8) ? 8'hFC : 8'($urandom_range(0, 62) * 4);
      d = $urandom;
      if ($urandom_range(0, 1) == 1) d[31:24] = 8'h88;
      wr(a, d);
      chk_out("R6 random outputs");
      rd(8'h18, "R3 random line readback");
      rd(8'hFC, "R5 random owner readback");
    end

    @(negedge clk); rst_n = 0; m_line = 0; m_own = 0; #1;
    chk_out("R1 outputs clear on reset");
    rd(8'h18, "R1 line reg clear on reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule